// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs the external bus transactions for a small 8-bit processor core. The core presents a read or write request with a 16-bit address, an 8-bit write byte, a memory-or-I/O select and an opcode-fetch flag. The controller turns that request into a bus cycle. The upper address byte goes out on its own pins. The lower address byte and the data byte share one set of pins, and a one-cycle address strobe marks when those pins hold the address. Active-low read and write strobes and an I/O-or-memory line go out with the cycle. A two-bit status code names the kind of operation.

Each cycle runs through four phases. The first phase carries the address and the strobe. The second phase lowers the read or write strobe and samples the ready input. Extra wait phases follow for as long as ready stays low. The last phase captures the read byte or completes the write. One cycle later the core receives a done pulse, and for a read it also gets the captured byte. An external master can take the bus with a hold request, which is granted only between cycles. While the grant is up, every pin group has its output enable low, so the pins are released.

The core holds its request steady until it sees done. The request is latched when the cycle starts, so later changes to the request inputs do not affect a cycle that is already running.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While rst is high, and in the first cycle after it, rd_n and wr_n are 1 and ale, hlda and done are 0.
- R2: A cycle starts when the controller is idle, req_valid is high, hold is low and done is low. In the first phase, ale is 1 for exactly one cycle, addr_hi carries req_addr[15:8], ad_out carries req_addr[7:0], and ad_oe is 1. In every later phase of the cycle, ale is 0.
- R3: A read (req_write=0) holds rd_n at 0 from the second phase through the last phase. During those phases wr_n stays 1 and ad_oe is 0.
- R4: A write (req_write=1) holds wr_n at 0 from the second phase through the last phase. During those phases rd_n stays 1, ad_oe is 1 and ad_out carries the write byte.
- R5: Throughout a cycle, io_m is 1 for an I/O request (req_io=1) and 0 for a memory request. Between cycles it is 0.
- R6: Throughout a cycle, sts is 2'b01 for a write, 2'b10 for a read and 2'b11 for a read with req_fetch=1. The fetch flag is ignored on a write. Between cycles sts is 2'b00.
- R7: When ready is sampled low at the end of the second phase or of a wait phase, one more wait phase follows with the strobe still low. A cycle with n wait phases keeps its strobe low for n+2 cycles.
- R8: done is a one-cycle pulse in the cycle after the last phase. For a read, rdata then holds the ad_in value that was present during the last phase.
- R9: When hold is sampled high while the controller is idle, hlda is 1 from the next cycle. While hlda is 1: addr_oe, ad_oe and ctl_oe are 0, ale is 0, rd_n and wr_n are 1, and no cycle starts. A hold raised during a cycle lets that cycle finish first.
- R10: hlda falls in the cycle after hold is sampled low. A pending request then starts one cycle later.
- R11: No cycle starts in the cycle in which done is 1, even if req_valid is still high. This leaves at least one idle cycle between two bus cycles.
- R12: The request inputs are latched when a cycle starts. Changes to req_addr, req_wdata, req_write, req_io or req_fetch after the first phase do not change the pins of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core requests a bus cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_io | input | 1 | 1 for the I/O space, 0 for memory |
| req_fetch | input | 1 | Read is an opcode fetch |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Byte to write |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte captured by the last read |
| hold | input | 1 | Another master asks for the bus |
| hlda | output | 1 | Bus granted to the other master |
| ready | input | 1 | Addressed device can complete the transfer |
| addr_hi | output | 8 | Upper address pins |
| addr_oe | output | 1 | Output enable of addr_hi |
| ad_out | output | 8 | Shared address/data pins, outgoing value |
| ad_in | input | 8 | Shared address/data pins, incoming value |
| ad_oe | output | 1 | Output enable of the shared pins |
| ale | output | 1 | Address strobe for the shared pins |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ctl_oe | output | 1 | Output enable of strobes, io_m and sts |
| io_m | output | 1 | 1 for I/O, 0 for memory |
| sts | output | 2 | Operation code of the current cycle |

## Verification
The assertions assume three things about the inputs. The core keeps req_valid high until done. ready is a clean level that is sampled only at clock edges. hold is released only after it has been granted. The stimulus drives every input half a step after a rising edge, holds each request from its start until the done cycle, and changes ready only inside the second or wait phases at the cycle boundary that the wait count calls for. hold is raised either while the controller is idle or during a running cycle, and it is dropped only while hlda is high.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_TW   = 3'd3,
    ST_T3   = 3'd4,
    ST_HOLD = 3'd5
  } bcc_state_e;

  localparam logic [1:0] STS_HALT  = 2'b00;
  localparam logic [1:0] STS_WRITE = 2'b01;
  localparam logic [1:0] STS_READ  = 2'b10;
  localparam logic [1:0] STS_FETCH = 2'b11;

  function automatic logic [1:0] sts_of(input logic is_wr, input logic is_fe);
    if (is_wr)      return STS_WRITE;
    else if (is_fe) return STS_FETCH;
    else            return STS_READ;
  endfunction

endpackage

// File: rtl/bcc_seq.sv
module bcc_seq
  import bcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       hold,
  input  logic       ready,
  input  logic       done_q,
  output bcc_state_e st,
  output bcc_state_e nxt,
  output logic       start
);

  always_comb begin
    nxt   = st;
    start = 1'b0;
    case (st)
      ST_IDLE: begin
        if (hold) begin
          nxt = ST_HOLD;
        end else if (req_valid && !done_q) begin
          nxt   = ST_T1;
          start = 1'b1;
        end
      end
      ST_T1:        nxt = ST_T2;
      ST_T2, ST_TW: nxt = ready ? ST_T3 : ST_TW;
      ST_T3:        nxt = ST_IDLE;
      ST_HOLD:      nxt = hold ? ST_HOLD : ST_IDLE;
      default:      nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= nxt;
  end

  // R7
  ready_stretch_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_T2 || st == ST_TW) && !ready) |=> (st == ST_TW));

  // R9
  hold_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_T1 || st == ST_T2 || st == ST_TW) |=> (st != ST_HOLD));

endmodule

// File: rtl/bcc_latch.sv
module bcc_latch #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic              in_wr,
  input  logic              in_io,
  input  logic              in_fe,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata,
  output logic              cur_wr,
  output logic              cur_io,
  output logic              cur_fe
);

  logic [ADDR_W-1:0] h_addr;
  logic [DATA_W-1:0] h_wdata;
  logic              h_wr, h_io, h_fe;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_addr  <= '0;
      h_wdata <= '0;
      h_wr    <= 1'b0;
      h_io    <= 1'b0;
      h_fe    <= 1'b0;
    end else if (start) begin
      h_addr  <= in_addr;
      h_wdata <= in_wdata;
      h_wr    <= in_wr;
      h_io    <= in_io;
      h_fe    <= in_fe;
    end
  end

  // The first phase takes the live request; later phases use the held copy.
  assign cur_addr  = start ? in_addr  : h_addr;
  assign cur_wdata = start ? in_wdata : h_wdata;
  assign cur_wr    = start ? in_wr    : h_wr;
  assign cur_io    = start ? in_io    : h_io;
  assign cur_fe    = start ? in_fe    : h_fe;

endmodule

// File: rtl/bcc_pins.sv
module bcc_pins
  import bcc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  bcc_state_e        nxt,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] cur_wdata,
  input  logic              cur_wr,
  input  logic              cur_io,
  input  logic              cur_fe,
  output logic [HI_W-1:0]   addr_hi,
  output logic              addr_oe,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              ctl_oe,
  output logic              io_m,
  output logic [1:0]        sts,
  output logic              hlda
);

  logic in_cyc, data_ph, first_ph, grant;

  assign first_ph = (nxt == ST_T1);
  assign data_ph  = (nxt == ST_T2) || (nxt == ST_TW) || (nxt == ST_T3);
  assign in_cyc   = first_ph || data_ph;
  assign grant    = (nxt == ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_hi <= '0;
      addr_oe <= 1'b1;
      ad_out  <= '0;
      ad_oe   <= 1'b0;
      ale     <= 1'b0;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      ctl_oe  <= 1'b1;
      io_m    <= 1'b0;
      sts     <= STS_HALT;
      hlda    <= 1'b0;
    end else begin
      ale     <= first_ph;
      rd_n    <= !(data_ph && !cur_wr);
      wr_n    <= !(data_ph && cur_wr);
      ad_oe   <= first_ph || (data_ph && cur_wr);
      addr_oe <= !grant;
      ctl_oe  <= !grant;
      hlda    <= grant;
      io_m    <= in_cyc ? cur_io : 1'b0;
      sts     <= in_cyc ? sts_of(cur_wr, cur_fe) : STS_HALT;
      if (first_ph) begin
        addr_hi <= cur_addr[ADDR_W-1:DATA_W];
        ad_out  <= cur_addr[DATA_W-1:0];
      end else if (data_ph && cur_wr) begin
        ad_out  <= cur_wdata;
      end
    end
  end

  // R2
  ale_single_chk: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  // R9
  hlda_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    hlda |-> (!ale && rd_n && wr_n && !ad_oe && !addr_oe && !ctl_oe));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> (wr_n && !ad_oe));

endmodule

// File: rtl/bcc_rdcap.sv
module bcc_rdcap
  import bcc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  bcc_state_e        st,
  input  logic              cyc_wr,
  input  logic [DATA_W-1:0] ad_in,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= (st == ST_T3);
      if (st == ST_T3 && !cyc_wr) rdata <= ad_in;
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bcc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic                     req_io,
  input  logic                     req_fetch,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     done,
  output logic [DATA_W-1:0]        rdata,
  input  logic                     hold,
  output logic                     hlda,
  input  logic                     ready,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic                     addr_oe,
  output logic [DATA_W-1:0]        ad_out,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     ad_oe,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     ctl_oe,
  output logic                     io_m,
  output logic [1:0]               sts
);

  bcc_state_e        st, nxt;
  logic              start;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic              cur_wr, cur_io, cur_fe;

  bcc_seq u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .hold(hold), .ready(ready),
    .done_q(done), .st(st), .nxt(nxt), .start(start)
  );

  bcc_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .start(start),
    .in_addr(req_addr), .in_wdata(req_wdata), .in_wr(req_write),
    .in_io(req_io), .in_fe(req_fetch),
    .cur_addr(cur_addr), .cur_wdata(cur_wdata), .cur_wr(cur_wr),
    .cur_io(cur_io), .cur_fe(cur_fe)
  );

  bcc_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst(rst), .nxt(nxt),
    .cur_addr(cur_addr), .cur_wdata(cur_wdata), .cur_wr(cur_wr),
    .cur_io(cur_io), .cur_fe(cur_fe),
    .addr_hi(addr_hi), .addr_oe(addr_oe), .ad_out(ad_out), .ad_oe(ad_oe),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ctl_oe(ctl_oe), .io_m(io_m),
    .sts(sts), .hlda(hlda)
  );

  bcc_rdcap #(.DATA_W(DATA_W)) u_rdcap (
    .clk(clk), .rst(rst), .st(st), .cyc_wr(cur_wr), .ad_in(ad_in),
    .done(done), .rdata(rdata)
  );

  // R10
  hold_release_chk: assert property (@(posedge clk) disable iff (rst)
    (hlda && !hold) |=> !hlda);

  // R11
  done_gap_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !ale);

  // R5
  io_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (sts == STS_HALT) |-> !io_m);

endmodule

// File: tb/tb_bus_cycle_ctrl.sv
module tb_bus_cycle_ctrl;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic        io;
    logic        fe;
    logic [15:0] a;
    logic [7:0]  d;
    logic [7:0]  rdin;
    logic [2:0]  nw;
    logic [1:0]  est;
  } vec_t;

  localparam int NV = 6;
  localparam logic [39:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 16'h2000, 8'h00, 8'h3E, 3'd0, 2'b11},
    {1'b0, 1'b0, 1'b0, 16'h5008, 8'h00, 8'hA5, 3'd2, 2'b10},
    {1'b1, 1'b0, 1'b0, 16'h40F1, 8'h5A, 8'h00, 3'd0, 2'b01},
    {1'b1, 1'b1, 1'b0, 16'h0025, 8'hC3, 8'h00, 3'd1, 2'b01},
    {1'b0, 1'b1, 1'b0, 16'h00FE, 8'h00, 8'h7F, 3'd3, 2'b10},
    {1'b1, 1'b0, 1'b1, 16'hFFFF, 8'h81, 8'h00, 3'd0, 2'b01}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0, req_fetch = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic hold = 1'b0, ready = 1'b1;
  logic [7:0] ad_in = '0;
  logic done, hlda, addr_oe, ad_oe, ale, rd_n, wr_n, ctl_oe, io_m;
  logic [7:0] rdata, addr_hi, ad_out;
  logic [1:0] sts;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cycle_ctrl dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_io(req_io), .req_fetch(req_fetch), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .rdata(rdata), .hold(hold),
    .hlda(hlda), .ready(ready), .addr_hi(addr_hi), .addr_oe(addr_oe),
    .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .ctl_oe(ctl_oe), .io_m(io_m), .sts(sts)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_cycle(input vec_t v);
    req_write = v.wr; req_io = v.io; req_fetch = v.fe;
    req_addr = v.a; req_wdata = v.d; req_valid = 1'b1;
    ready = (v.nw == 0); ad_in = v.rdin;
    tick(); // first phase
    check("R2 ale in first phase", ale, 1);
    check("R2 addr_hi", addr_hi, v.a[15:8]);
    check("R2 ad_out low address", ad_out, v.a[7:0]);
    check("R2 ad_oe", ad_oe, 1);
    check("R5 io_m first phase", io_m, v.io);
    check("R6 sts first phase", sts, v.est);
    check("R3 rd_n high in first phase", rd_n, 1);
    check("R4 wr_n high in first phase", wr_n, 1);
    // R12: scramble the request after it was taken
    req_addr = ~v.a; req_wdata = ~v.d; req_write = ~v.wr;
    req_io = ~v.io; req_fetch = ~v.fe;
    tick(); // second phase
    check("R2 ale low after first phase", ale, 0);
    check("R3 rd_n second phase", rd_n, v.wr ? 1 : 0);
    check("R4 wr_n second phase", wr_n, v.wr ? 0 : 1);
    check("R3 R4 ad_oe second phase", ad_oe, v.wr);
    if (v.wr) check("R4 R12 write byte", ad_out, v.d);
    check("R12 addr_hi held", addr_hi, v.a[15:8]);
    check("R12 io_m held", io_m, v.io);
    check("R12 sts held", sts, v.est);
    for (int i = 0; i < v.nw; i++) begin
      tick(); // wait phase
      check("R7 strobe low in wait", v.wr ? wr_n : rd_n, 0);
      check("R7 no done in wait", done, 0);
      if (i == v.nw - 1) ready = 1'b1;
    end
    tick(); // last phase
    check("R7 strobe low in last phase", v.wr ? wr_n : rd_n, 0);
    check("R8 no done in last phase", done, 0);
    tick(); // done cycle
    check("R8 done pulse", done, 1);
    check("R8 rd_n released", rd_n, 1);
    check("R8 wr_n released", wr_n, 1);
    check("R6 sts idle", sts, 2'b00);
    check("R5 io_m idle", io_m, 0);
    if (!v.wr) check("R8 rdata", rdata, v.rdin);
    tick(); // req_valid still high: no start in done cycle
    check("R11 no start after done", ale, 0);
    check("R8 done single pulse", done, 0);
    req_valid = 1'b0;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    vec_t v;
    tick(); tick();
    check("R1 rd_n in reset", rd_n, 1);
    check("R1 wr_n in reset", wr_n, 1);
    check("R1 ale in reset", ale, 0);
    check("R1 hlda in reset", hlda, 0);
    check("R1 done in reset", done, 0);
    rst = 1'b0;
    tick();
    check("R1 idle after reset", {ale, rd_n, wr_n, hlda}, 4'b0110);

    for (int k = 0; k < NV; k++) begin
      v = vec_t'(VEC[k]);
      run_cycle(v);
    end

    // R11: back-to-back request, one idle gap
    v = vec_t'({1'b0, 1'b0, 1'b0, 16'h1234, 8'h00, 8'h99, 3'd0, 2'b10});
    run_cycle(v);

    // R9 hold while idle
    hold = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = 16'hABCD;
    tick();
    check("R9 hlda rises", hlda, 1);
    check("R9 addr_oe off", addr_oe, 0);
    check("R9 ad_oe off", ad_oe, 0);
    check("R9 ctl_oe off", ctl_oe, 0);
    tick();
    check("R9 no cycle during grant", {ale, rd_n, wr_n}, 3'b011);
    hold = 1'b0;
    tick();
    check("R10 hlda falls", hlda, 0);
    check("R10 oe back", {addr_oe, ctl_oe}, 2'b11);
    tick();
    check("R10 pending request starts", ale, 1);
    check("R10 address after hold", addr_hi, 8'hAB);
    tick(); // second phase
    hold = 1'b1; // R9: raised inside a cycle
    tick(); // last phase
    check("R9 cycle finishes under hold", rd_n, 0);
    check("R9 no grant mid-cycle", hlda, 0);
    tick(); // done
    check("R9 done before grant", done, 1);
    check("R9 grant waits for boundary", hlda, 0);
    req_valid = 1'b0;
    tick();
    check("R9 grant after cycle", hlda, 1);
    hold = 1'b0;
    tick();
    check("R10 release", hlda, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule